// File: doc/BRIEF.md
# Operand Bypass Selector

This block picks the value each of the two source operands of an in-order five-stage pipeline should use. It compares each operand's register index with the destinations of the results sitting in the memory stage and the write-back stage. A newer result that is still in flight then replaces the stale register-file read.

The logic is purely combinational and holds no state. Each later stage presents a destination index, a result value and a write-enable flag. For each operand the block returns the chosen value and a 2-bit code that names where the value came from. Stalls and load-use interlocks belong to a separate hazard unit.

Top module: `operand_bypass`

## Requirements
- R1: When neither later stage qualifies for an operand, that operand's output equals its register-file value and its select code is 2'b00.
- R2: When the memory stage has its write enable set and its destination equals a nonzero operand index, the operand takes the memory-stage value and its select code is 2'b01.
- R3: When only the write-back stage has its enable set and a matching destination for a nonzero operand index, the operand takes the write-back value and its select code is 2'b10.
- R4: When both stages qualify for the same operand, the memory-stage value wins, with select code 2'b01.
- R5: A stage whose write enable is low never supplies a value, even when its destination index matches.
- R6: Operand index 0 is never bypassed. The register-file value is passed through with select code 2'b00, whatever the stage destinations and enables are.
- R7: The two operands are resolved independently, so each one can pick a different source in the same evaluation.
- R8: The select code 2'b11 never appears on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_idx | input | IDX_W | Register index of the first source operand |
| rt_idx | input | IDX_W | Register index of the second source operand |
| rs_rf | input | DATA_W | Register-file read value for the first operand |
| rt_rf | input | DATA_W | Register-file read value for the second operand |
| mem_dst | input | IDX_W | Destination index of the memory-stage result |
| mem_val | input | DATA_W | Memory-stage result value |
| mem_we | input | 1 | Memory-stage result will be written |
| wb_dst | input | IDX_W | Destination index of the write-back result |
| wb_val | input | DATA_W | Write-back result value |
| wb_we | input | 1 | Write-back result will be written |
| rs_out | output | DATA_W | Value chosen for the first operand |
| rt_out | output | DATA_W | Value chosen for the second operand |
| rs_sel | output | 2 | Source code for the first operand (00 file, 01 memory, 10 write-back) |
| rt_sel | output | 2 | Source code for the second operand |

## Verification
The hardest case to provoke is a single evaluation that exercises priority, enable masking and the zero-index exclusion together. That needs both stages to target one index while one enable is dropped, or the index to be zero. The vector table builds these cases directly by aliasing the stage destinations onto the operand indices with selected enables cleared. Every stage value is distinct, so a wrong choice shows up in the data as well as in the code.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [DATA_W-1:0] rs_rf,
  input  logic [DATA_W-1:0] rt_rf,
  input  logic [IDX_W-1:0]  mem_dst,
  input  logic [DATA_W-1:0] mem_val,
  input  logic              mem_we,
  input  logic [IDX_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_val,
  input  logic              wb_we,
  output logic [DATA_W-1:0] rs_out,
  output logic [DATA_W-1:0] rt_out,
  output logic [1:0]        rs_sel,
  output logic [1:0]        rt_sel
);
  localparam logic [1:0] SRC_RF  = 2'b00;
  localparam logic [1:0] SRC_MEM = 2'b01;
  localparam logic [1:0] SRC_WB  = 2'b10;

  logic [IDX_W-1:0]  idx [2];
  logic [DATA_W-1:0] rf  [2];
  logic [DATA_W-1:0] val [2];
  logic [1:0]        sel [2];

  assign idx[0] = rs_idx;
  assign idx[1] = rt_idx;
  assign rf[0]  = rs_rf;
  assign rf[1]  = rt_rf;

  for (genvar g = 0; g < 2; g++) begin : g_op
    logic live, hit_mem, hit_wb;
    assign live    = |idx[g];
    assign hit_mem = live && mem_we && (mem_dst == idx[g]);
    assign hit_wb  = live && wb_we  && (wb_dst  == idx[g]);
    assign sel[g]  = hit_mem ? SRC_MEM : (hit_wb ? SRC_WB : SRC_RF);
    always_comb begin
      unique case (sel[g])
        SRC_MEM: val[g] = mem_val;
        SRC_WB:  val[g] = wb_val;
        default: val[g] = rf[g];
      endcase
    end
  end

  assign rs_out = val[0];
  assign rt_out = val[1];
  assign rs_sel = sel[0];
  assign rt_sel = sel[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic [IDX_W-1:0]  rs_idx,
  input logic [IDX_W-1:0]  rt_idx,
  input logic [DATA_W-1:0] rs_rf,
  input logic [DATA_W-1:0] rt_rf,
  input logic [IDX_W-1:0]  mem_dst,
  input logic [DATA_W-1:0] mem_val,
  input logic              mem_we,
  input logic [IDX_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_val,
  input logic              wb_we,
  input logic [DATA_W-1:0] rs_out,
  input logic [DATA_W-1:0] rt_out,
  input logic [1:0]        rs_sel,
  input logic [1:0]        rt_sel
);
  always_comb begin
    // R2
    rs_mem_win_chk: assert (!(mem_we && rs_idx != '0 && mem_dst == rs_idx) || (rs_sel == 2'b01 && rs_out == mem_val));
    // R2
    rt_mem_win_chk: assert (!(mem_we && rt_idx != '0 && mem_dst == rt_idx) || (rt_sel == 2'b01 && rt_out == mem_val));
    // R6
    rs_zero_chk: assert (rs_idx != '0 || (rs_sel == 2'b00 && rs_out == rs_rf));
    // R6
    rt_zero_chk: assert (rt_idx != '0 || (rt_sel == 2'b00 && rt_out == rt_rf));
    // R5
    rs_no_en_chk: assert ((mem_we || wb_we) || rs_sel == 2'b00);
    // R5
    rt_no_en_chk: assert ((mem_we || wb_we) || rt_sel == 2'b00);
    // R8
    sel_legal_chk: assert (rs_sel != 2'b11 && rt_sel != 2'b11);
  end
endmodule

bind operand_bypass operand_bypass_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/operand_bypass_test.sv
module operand_bypass_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam logic [DW-1:0] RS_RF = 32'h1111_0003;
  localparam logic [DW-1:0] RT_RF = 32'h2222_0004;
  localparam logic [DW-1:0] MEMV  = 32'hAAAA_0001;
  localparam logic [DW-1:0] WBV   = 32'hBBBB_0002;

  typedef struct packed {
    logic [IW-1:0] rsi, rti, md, wd;
    logic          mwe, wwe;
    logic [1:0]    ers, ert;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd7,  5'd8,  1'b1, 1'b1, 2'd0, 2'd0},  // R1
    '{5'd3,  5'd4,  5'd3,  5'd8,  1'b1, 1'b1, 2'd1, 2'd0},  // R2
    '{5'd3,  5'd4,  5'd9,  5'd4,  1'b1, 1'b1, 2'd0, 2'd2},  // R3
    '{5'd5,  5'd5,  5'd5,  5'd5,  1'b1, 1'b1, 2'd1, 2'd1},  // R4
    '{5'd5,  5'd6,  5'd5,  5'd6,  1'b0, 1'b1, 2'd0, 2'd2},  // R5
    '{5'd5,  5'd6,  5'd5,  5'd5,  1'b0, 1'b1, 2'd2, 2'd0},  // R5
    '{5'd0,  5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 2'd0, 2'd0},  // R6
    '{5'd31, 5'd31, 5'd31, 5'd2,  1'b1, 1'b0, 2'd1, 2'd1},  // R2
    '{5'd7,  5'd9,  5'd9,  5'd7,  1'b1, 1'b1, 2'd2, 2'd1},  // R7
    '{5'd0,  5'd12, 5'd0,  5'd12, 1'b1, 1'b1, 2'd0, 2'd2},  // R6
    '{5'd4,  5'd4,  5'd4,  5'd4,  1'b0, 1'b0, 2'd0, 2'd0}   // R5
  };

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [IW-1:0] rs_idx, rt_idx, mem_dst, wb_dst;
  logic [DW-1:0] rs_rf, rt_rf, mem_val, wb_val, rs_out, rt_out;
  logic mem_we, wb_we;
  logic [1:0] rs_sel, rt_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  operand_bypass #(.DATA_W(DW), .IDX_W(IW)) uut (.*);

  function automatic logic [DW-1:0] pick(logic [1:0] s, logic [DW-1:0] rfv);
    return s == 2'd1 ? MEMV : (s == 2'd2 ? WBV : rfv);
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(posedge clk);
    rs_idx = v.rsi; rt_idx = v.rti; mem_dst = v.md; wb_dst = v.wd;
    mem_we = v.mwe; wb_we = v.wwe;
    @(negedge clk);
  endtask

  initial begin
    rs_rf = RS_RF; rt_rf = RT_RF; mem_val = MEMV; wb_val = WBV;
    rs_idx = '0; rt_idx = '0; mem_dst = '0; wb_dst = '0; mem_we = 0; wb_we = 0;
    @(negedge clk);
    // R1 idle state: everything from the register file
    chk("R1 idle rs_sel", {30'd0, rs_sel}, 32'd0);
    chk("R1 idle rt_out", rt_out, RT_RF);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk($sformatf("R1-R7 vec%0d rs_sel", i), {30'd0, rs_sel}, {30'd0, VECS[i].ers});
      chk($sformatf("R1-R7 vec%0d rt_sel", i), {30'd0, rt_sel}, {30'd0, VECS[i].ert});
      chk($sformatf("vec%0d rs_out", i), rs_out, pick(VECS[i].ers, RS_RF));
      chk($sformatf("vec%0d rt_out", i), rt_out, pick(VECS[i].ert, RT_RF));
      // R8
      chk("R8 no code 11", {31'd0, (rs_sel == 2'b11 || rt_sel == 2'b11)}, 32'd0);
    end

    // R6 zero index with both stages enabled on index 0 and a changed file value
    apply('{5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 2'd0, 2'd0});
    rs_rf = 32'h0; #1;
    chk("R6 zero rs_out follows file", rs_out, 32'h0);
    rs_rf = RS_RF;
    // R4 priority holds when the stage values are swapped
    apply('{5'd10, 5'd10, 5'd10, 5'd10, 1'b1, 1'b1, 2'd1, 2'd1});
    mem_val = WBV; wb_val = MEMV; #1;
    chk("R4 mem wins swapped values", rs_out, WBV);
    mem_val = MEMV; wb_val = WBV;
    // R7 each operand picks a different stage
    apply('{5'd1, 5'd2, 5'd2, 5'd1, 1'b1, 1'b1, 2'd2, 2'd1});
    chk("R7 rs from wb", rs_out, WBV);
    chk("R7 rt from mem", rt_out, MEMV);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule